// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Engine

This block is a serial master for the control port of a display panel that speaks in 9-bit words. The top bit of each word tells the panel whether the other 8 bits are an opcode or a parameter. A host starts a transaction with one request. The request carries an opcode, a count of parameter bytes to write, a count of bytes to read back, and a clock divider setting. The engine lowers chip select and sends the opcode word. It then pulls each parameter byte, with its own flag bit, through a valid/ready port and sends it. Last, it clocks in the requested read bytes and hands each one out with a strobe.

The serial clock runs in mode 0. It idles low, data is driven while the clock is low, and data is sampled on the rising edge. Chip select stays low for the whole transaction. When more than one byte is read, the first read word takes one extra clock before its first data bit, and that bit is thrown away. A single-byte read takes exactly eight clocks. A one-cycle done pulse follows the release of chip select. Requests that arrive while a transaction is running are dropped.

Typical transactions:
- A bare opcode such as display on (0x29) or sleep out (0x11).
- A pixel-format opcode (0x3A) with one parameter word, such as 0x170.
- An identification read (0x04) that returns three bytes.

Top module: `spi9_cmd_engine`

## Requirements
- R1: After reset and between transactions, chip select is high, the serial clock is low, data out is low, and busy is low.
- R2: The first word of a transaction is 9 bits, sent MSB first. Its first bit is 0 and the 8 opcode bits follow, bit 7 first.
- R3: The engine sends exactly the requested number of parameter words. Each byte is taken on a cycle where valid and ready are both high. Each word is sent as the byte's flag bit followed by its 8 data bits, bit 7 first.
- R4: The serial clock is mode 0. Data out changes only while the clock is low, and data in is sampled at each rising edge.
- R5: A one-byte read takes 8 clocks right after the last written word. The byte is the 8 sampled bits, with the first sampled bit as bit 7.
- R6: A read of N>1 bytes takes 8N+1 clocks. The first sampled bit is discarded, and N bytes are then assembled, 8 bits each, MSB first. A read strobe fires once per byte.
- R7: Words go out in this order: opcode, then parameters, then reads. Chip select stays low throughout. The total number of rising clock edges is 9 + 9W + (0 if R=0, 8 if R=1, 8R+1 if R>1), where W is the parameter count and R is the read count.
- R8: At least two half periods pass between the fall of chip select and the first rising clock edge. At least two half periods pass between the last falling clock edge and the rise of chip select.
- R9: Done is high for exactly one cycle per transaction, on the cycle after chip select rises.
- R10: A request that arrives while busy is high has no effect on the transaction in progress and does not start another one.
- R11: Each high half period of the serial clock lasts div+1 system clock cycles, where div is the divider value captured with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start request (taken only when idle) |
| req_cmd_i | input | 8 | Opcode byte |
| req_nwr_i | input | CNT_W | Number of parameter bytes to send |
| req_nrd_i | input | CNT_W | Number of bytes to read |
| req_div_i | input | DIV_W | Half period of the serial clock, minus one, in system cycles |
| busy_o | output | 1 | Transaction in progress |
| par_valid_i | input | 1 | Parameter byte available |
| par_flag_i | input | 1 | Flag bit for this parameter word |
| par_data_i | input | 8 | Parameter byte |
| par_ready_o | output | 1 | Engine takes a parameter byte this cycle |
| rd_valid_o | output | 1 | Read byte strobe |
| rd_data_o | output | 8 | Read byte |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |

## Verification
The assertions assume the following about the inputs:
- The reset is applied before the first request.
- The peripheral changes data in only while the serial clock is low.
- Parameter bytes stay stable while valid is high and ready is low.

The stimulus meets these conditions in the following ways:
- The slave model in the bench updates data in only when it sees chip select or the serial clock fall.
- Parameter bytes change only after an observed handshake.
- All inputs are driven away from the active clock edge.

The sweep covers divider values 0 to 2, 0 to 3 parameter bytes, and 0 to 4 read bytes. In every transaction a second, conflicting request is sent while busy is high, to check that it is ignored.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  localparam int WORD_W = 9;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_LOAD,
    ST_WAITP,
    ST_HOLD,
    ST_FIN
  } st_e;
endpackage

// File: rtl/spi9_tick.sv
module spi9_tick #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] lim_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= lim_i); // R11
endmodule

// File: rtl/spi9_shift.sv
module spi9_shift
  import spi9_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_o
);
  logic [WORD_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_q <= '0;
    else if (load_i)  tx_q <= word_i;
    else if (shift_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
  end

  // older bits fall off the top, so a leading dummy bit is dropped for free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= {rx_q[BYTE_W-2:0], miso_i};
  end

  assign mosi_o = tx_q[WORD_W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi9_cmd_engine.sv
module spi9_cmd_engine
  import spi9_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [7:0]       req_cmd_i,
  input  logic [CNT_W-1:0] req_nwr_i,
  input  logic [CNT_W-1:0] req_nrd_i,
  input  logic [DIV_W-1:0] req_div_i,
  output logic             busy_o,
  input  logic             par_valid_i,
  input  logic             par_flag_i,
  input  logic [7:0]       par_data_i,
  output logic             par_ready_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             done_o,
  output logic             spi_cs_no,
  output logic             spi_sck_o,
  output logic             spi_mosi_o,
  input  logic             spi_miso_i
);
  st_e               st_q;
  logic              cs_n_q, sck_q, ph_q, done_q, rdv_q;
  logic              multi_q, first_rd_q, rd_mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  wr_left_q, rd_left_q;
  logic [BIT_W-1:0]  bit_left_q;
  logic [BYTE_W-1:0] rdd_q, rx;
  logic              tick, tick_en, accept, hs, rise, fall, word_end;
  logic              ld, load_rd, tx_bit;
  logic [WORD_W-1:0] ld_word;

  assign tick_en  = (st_q == ST_SETUP) || (st_q == ST_SHIFT) || (st_q == ST_HOLD);
  assign accept   = (st_q == ST_IDLE) && req_valid_i;
  assign hs       = (st_q == ST_WAITP) && par_valid_i;
  assign rise     = (st_q == ST_SHIFT) && tick && !sck_q;
  assign fall     = (st_q == ST_SHIFT) && tick && sck_q;
  assign word_end = fall && (bit_left_q == '0);
  assign load_rd  = (st_q == ST_LOAD) && (wr_left_q == '0) && (rd_left_q != '0);
  assign ld       = accept || hs || load_rd;
  assign ld_word  = accept ? {1'b0, req_cmd_i} :
                    hs     ? {par_flag_i, par_data_i} : '0;

  spi9_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en),
    .lim_i  (div_q),
    .tick_o (tick)
  );

  spi9_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ld),
    .word_i   (ld_word),
    .shift_i  (fall && (bit_left_q != '0)),
    .sample_i (rise),
    .miso_i   (spi_miso_i),
    .mosi_o   (tx_bit),
    .rx_o     (rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cs_n_q     <= 1'b1;
      sck_q      <= 1'b0;
      ph_q       <= 1'b0;
      done_q     <= 1'b0;
      rdv_q      <= 1'b0;
      rdd_q      <= '0;
      multi_q    <= 1'b0;
      first_rd_q <= 1'b0;
      rd_mode_q  <= 1'b0;
      div_q      <= '0;
      wr_left_q  <= '0;
      rd_left_q  <= '0;
      bit_left_q <= '0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          cs_n_q     <= 1'b0;
          div_q      <= req_div_i;
          wr_left_q  <= req_nwr_i;
          rd_left_q  <= req_nrd_i;
          multi_q    <= req_nrd_i > CNT_W'(1);
          first_rd_q <= 1'b1;
          rd_mode_q  <= 1'b0;
          bit_left_q <= BIT_W'(WORD_W - 1);
          ph_q       <= 1'b0;
          st_q       <= ST_SETUP;
        end
        ST_SETUP: if (tick) begin
          ph_q <= ~ph_q;
          if (ph_q) st_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (rise) sck_q <= 1'b1;
          if (fall) begin
            sck_q <= 1'b0;
            if (bit_left_q == '0) begin
              st_q <= ST_LOAD;
              if (rd_mode_q) begin
                rdv_q     <= 1'b1;
                rdd_q     <= rx;
                rd_left_q <= rd_left_q - 1'b1;
              end
            end else begin
              bit_left_q <= bit_left_q - 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (wr_left_q != '0) begin
            st_q <= ST_WAITP;
          end else if (rd_left_q != '0) begin
            rd_mode_q  <= 1'b1;
            first_rd_q <= 1'b0;
            bit_left_q <= (first_rd_q && multi_q) ? BIT_W'(BYTE_W) : BIT_W'(BYTE_W - 1);
            st_q       <= ST_SHIFT;
          end else begin
            ph_q <= 1'b0;
            st_q <= ST_HOLD;
          end
        end
        ST_WAITP: if (hs) begin
          wr_left_q  <= wr_left_q - 1'b1;
          bit_left_q <= BIT_W'(WORD_W - 1);
          st_q       <= ST_SHIFT;
        end
        ST_HOLD: if (tick) begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            cs_n_q <= 1'b1;
            st_q   <= ST_FIN;
          end
        end
        ST_FIN: begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign par_ready_o = (st_q == ST_WAITP);
  assign rd_valid_o  = rdv_q;
  assign rd_data_o   = rdd_q;
  assign done_o      = done_q;
  assign spi_cs_no   = cs_n_q;
  assign spi_sck_o   = sck_q;
  assign spi_mosi_o  = (st_q == ST_SHIFT) && tx_bit;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o && !spi_mosi_o); // R1
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> $stable(spi_mosi_o)); // R4
  AST_PAR_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_ready_o |-> !spi_cs_no && !spi_sck_o); // R7
  AST_RD_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !spi_cs_no); // R6
  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> spi_cs_no && $past(spi_cs_no) && !$past(spi_cs_no, 2)); // R9
endmodule

// File: tb/spi9_cmd_engine_tb_top.sv
module spi9_cmd_engine_tb_top;
  localparam int CNT_W = 4;
  localparam int DIV_W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             req_valid;
  logic [7:0]       req_cmd;
  logic [CNT_W-1:0] req_nwr, req_nrd;
  logic [DIV_W-1:0] req_div;
  logic             busy, par_ready, rd_valid, done, cs_n, sck, mosi;
  logic             par_valid, par_flag, miso;
  logic [7:0]       par_data, rd_data;

  spi9_cmd_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_cmd_i(req_cmd), .req_nwr_i(req_nwr),
    .req_nrd_i(req_nrd), .req_div_i(req_div), .busy_o(busy),
    .par_valid_i(par_valid), .par_flag_i(par_flag), .par_data_i(par_data),
    .par_ready_o(par_ready), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .done_o(done), .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi),
    .spi_miso_i(miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model and monitor state
  int   cyc = 0, rise_cnt, cs_fall_cyc, rise_cyc, fall_cyc, cs_rise_cyc;
  int   setup_len, hold_len, width_err, done_cnt, done_cyc, rd_n;
  int   seed, cur_div, pidx, n_par;
  bit   hs_pend;
  logic bits [0:511];
  logic [7:0] rd_got [0:15];
  logic [8:0] pw [0:15];
  logic prev_sck = 1'b0, prev_cs = 1'b1;

  function automatic logic fbit(input int k, input int s);
    return logic'(((k * 13 + s) >> 2) % 2);
  endfunction

  function automatic logic [7:0] opc(input int i);
    case (i % 7)
      0: return 8'h04;
      1: return 8'h10;
      2: return 8'h11;
      3: return 8'h28;
      4: return 8'h29;
      5: return 8'h3A;
      default: return 8'hC2;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      cs_fall_cyc = cyc;
      miso = fbit(0, seed);
    end
    if (!prev_sck && sck) begin
      if (rise_cnt < 512) bits[rise_cnt] = mosi;
      if (rise_cnt == 0) setup_len = cyc - cs_fall_cyc;
      rise_cnt++;
      rise_cyc = cyc;
    end
    if (prev_sck && !sck) begin
      if (cyc - rise_cyc != cur_div + 1) width_err++;
      fall_cyc = cyc;
      miso = fbit(rise_cnt, seed);
    end
    if (!prev_cs && cs_n) begin
      hold_len = cyc - fall_cyc;
      cs_rise_cyc = cyc;
    end
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
    end
    if (rd_valid) begin
      if (rd_n < 16) rd_got[rd_n] = rd_data;
      rd_n++;
    end
    if (hs_pend) pidx++;
    par_valid = (pidx < n_par);
    par_flag  = (pidx < 16) ? pw[pidx][8] : 1'b0;
    par_data  = (pidx < 16) ? pw[pidx][7:0] : 8'h00;
    hs_pend   = par_valid && par_ready;
    prev_sck  = sck;
    prev_cs   = cs_n;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_nwr = '0; req_nrd = '0;
    req_div = '0; miso = 1'b0; par_valid = 1'b0; par_flag = 1'b0; par_data = '0;
    n_par = 0; pidx = 0; hs_pend = 0; seed = 0; cur_div = 0;
    rise_cnt = 0; rd_n = 0; done_cnt = 0; width_err = 0;
    cs_fall_cyc = 0; rise_cyc = 0; fall_cyc = 0; cs_rise_cyc = 0;
    setup_len = 0; hold_len = 0; done_cyc = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet bus after reset
    chk(cs_n == 1'b1, "R1 cs", int'(cs_n), 1);
    chk(sck == 1'b0 && mosi == 1'b0, "R1 sck/mosi", int'({sck, mosi}), 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'({busy, done}), 0);

    for (int d = 0; d < 3; d++) begin
      for (int w = 0; w < 4; w++) begin
        for (int r = 0; r < 5; r++) begin
          int        exp_rises, base, dummy, tr;
          logic [7:0] cmd, eb;
          logic [8:0] got;
          tr = d * 20 + w * 5 + r;
          cmd = opc(tr);
          @(posedge clk); #1;
          rise_cnt = 0; rd_n = 0; done_cnt = 0; width_err = 0;
          setup_len = 0; hold_len = 0; done_cyc = 0; cs_rise_cyc = 0;
          cur_div = d; seed = tr * 3 + 1; pidx = 0; hs_pend = 0; n_par = w;
          for (int i = 0; i < 16; i++)
            pw[i] = {(i % 3 != 1), 8'(cmd * 3 + i * 29 + d + 8'h40)};
          req_valid = 1'b1; req_cmd = cmd; req_nwr = CNT_W'(w);
          req_nrd = CNT_W'(r); req_div = DIV_W'(d);
          @(posedge clk); #1;
          req_valid = 1'b0;
          repeat (4) @(posedge clk);
          #1;
          chk(busy == 1'b1, "R10 busy during frame", int'(busy), 1);
          // R10: conflicting request while busy
          req_valid = 1'b1; req_cmd = 8'hFF; req_nwr = CNT_W'(2);
          req_nrd = CNT_W'(3); req_div = DIV_W'(0);
          @(posedge clk); #1;
          req_valid = 1'b0;
          for (int k = 0; k < 5000 && done_cnt == 0; k++) @(posedge clk);
          repeat (8) @(posedge clk);
          #1;

          exp_rises = 9 + 9 * w + ((r == 0) ? 0 : (r == 1) ? 8 : 8 * r + 1);
          chk(rise_cnt == exp_rises, "R7 clock count", rise_cnt, exp_rises);
          for (int b = 0; b < 9; b++) got[8 - b] = bits[b];
          chk(got == {1'b0, cmd}, "R2 command word", int'(got), int'({1'b0, cmd}));
          for (int i = 0; i < w; i++) begin
            for (int b = 0; b < 9; b++) got[8 - b] = bits[9 + 9 * i + b];
            chk(got == pw[i], "R3 parameter word", int'(got), int'(pw[i]));
          end
          chk(pidx == w, "R3 parameter handshakes", pidx, w);
          chk(rd_n == r, "R6 read strobes", rd_n, r);
          base  = 9 + 9 * w;
          dummy = (r > 1) ? 1 : 0;
          for (int j = 0; j < r && j < 16; j++) begin
            for (int b = 0; b < 8; b++) eb[7 - b] = fbit(base + dummy + 8 * j + b, seed);
            if (r == 1) chk(rd_got[j] == eb, "R5 R4 single read", int'(rd_got[j]), int'(eb));
            else        chk(rd_got[j] == eb, "R6 R4 multi read", int'(rd_got[j]), int'(eb));
          end
          chk(width_err == 0, "R11 high half period", width_err, 0);
          chk(setup_len >= 2 * (d + 1), "R8 cs setup", setup_len, 2 * (d + 1));
          chk(hold_len >= 2 * (d + 1), "R8 cs hold", hold_len, 2 * (d + 1));
          chk(done_cnt == 1, "R9 R10 single done", done_cnt, 1);
          chk(done_cyc - cs_rise_cyc == 1, "R9 done timing", done_cyc - cs_rise_cyc, 1);
          chk(cs_n == 1'b1 && busy == 1'b0, "R1 idle after frame", int'({cs_n, busy}), 2);
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule